// File: doc/BRIEF.md
# Per-Bank Precharge Timing Tracker

This block watches the activate, write and precharge commands that a scheduler sends to an SDRAM device and keeps, for every bank, the timing state a precharge depends on. Each bank gets a "precharge allowed" flag. The flag is low while the bank's page is too young, measured from its last activate, or while its last write is too recent. Each bank also gets a "page must close" request, which rises once the page has stayed open past a coarse limit counted in units of 1024 clock cycles.

All three timing values are plain configuration inputs, counted in controller clock cycles. They are held static while commands flow. Commands are single-cycle strobes with a shared bank address. The block always accepts them, so there is no back-pressure: a strobe that is high at a rising edge takes effect at that edge, and the scheduler must raise at most one strobe per cycle. The outputs are level status pins that the scheduler reads before it picks its next command.

Top module: `bank_pre_tracker`

## Requirements
- R1: After reset, every bit of `pre_ok` is 1, every bit of `force_close` is 0 and `wr_err` is 0. A bank with no open page always reports `pre_ok` = 1.
- R2: After an activate to bank b at clock edge E, `pre_ok[b]` reads 0 after edges E..E+k-1 and 1 after edge E+k, where k = `cfg_ras_min`. A value of 0 allows the precharge immediately.
- R3: After a write to an open bank b at edge W, `pre_ok[b]` stays 0 until edge W+`cfg_wr2pre` has passed, and is 1 from then on if R2 is also met.
- R4: `pre_ok[b]` is the AND of the R2 and R3 conditions. A later write to the same bank restarts the R3 delay.
- R5: `cfg_ras_max` gives the page-open limit in units of 1024 cycles. `force_close[b]` is still 0 exactly `cfg_ras_max`*1024 cycles after the activate, and is 1 at (`cfg_ras_max`+1)*1024 cycles. It rises on a shared prescaler tick.
- R6: A `cfg_ras_max` of 0 is treated as 1.
- R7: A precharge to bank b closes the page. At the next cycle, `pre_ok[b]` is 1 and `force_close[b]` is 0, whatever the timers held.
- R8: A write to a bank with no open page pulses `wr_err` high for exactly the next cycle. It leaves that bank closed, with `pre_ok` = 1.
- R9: Banks are independent. A command to one bank changes no other bank's `pre_ok` or `force_close`.
- R10: At most one of `act_vld`, `wr_vld` and `pre_vld` is high in any cycle. This rule binds the scheduler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_vld | input | 1 | Activate strobe |
| wr_vld | input | 1 | Write strobe |
| pre_vld | input | 1 | Precharge strobe |
| cmd_bank | input | BANK_W | Bank addressed by the strobe |
| cfg_ras_min | input | 6 | Minimum activate-to-precharge, cycles |
| cfg_ras_max | input | 7 | Maximum page-open time, units of 1024 cycles |
| cfg_wr2pre | input | 7 | Minimum write-to-precharge, cycles |
| pre_ok | output | NUM_BANKS | Per-bank precharge allowed |
| force_close | output | NUM_BANKS | Per-bank page-must-close request |
| wr_err | output | 1 | Write to a closed bank, one-cycle pulse |

## Verification
Every result comes out of one register stage. `wr_err` and the `pre_ok`/`force_close` change caused by a command are visible in the cycle after the strobe's edge. The R2 and R3 flags turn on exactly k edges after the command. The bench drives on falling edges and samples at the falling edge after each counted rising edge, so a sweep index k matches the edge count in the requirement directly. The page-open limit depends on the prescaler phase, so it is checked as a window: low at exactly limit×1024 cycles and high at (limit+1)×1024 cycles.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int RAS_MIN_W = 6;
  localparam int WR2PRE_W  = 7;
  localparam int RAS_MAX_W = 7;
  localparam int TICK_W    = 10;
  localparam int OPEN_W    = RAS_MAX_W + 1;

  typedef struct packed {
    logic [RAS_MIN_W-1:0] ras_min;
    logic [WR2PRE_W-1:0]  wr2pre;
    logic [RAS_MAX_W-1:0] ras_max;
  } timing_cfg_t;
endpackage

// File: rtl/bpt_prescaler.sv
module bpt_prescaler #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tick = &cnt;
endmodule

// File: rtl/bpt_bank.sv
module bpt_bank
  import bpt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        do_act,
  input  logic        do_wr,
  input  logic        do_pre,
  input  logic        tick,
  input  timing_cfg_t cfg,
  output logic        is_open,
  output logic        pre_ok,
  output logic        force_close
);
  localparam logic [RAS_MIN_W-1:0] ACT_SAT = '1;
  localparam logic [WR2PRE_W-1:0]  WR_SAT  = '1;

  logic                 open_q;
  logic [RAS_MIN_W-1:0] act_cnt;
  logic [WR2PRE_W-1:0]  wr_cnt;
  logic [OPEN_W-1:0]    open_cnt;
  logic [RAS_MAX_W-1:0] eff_max;
  logic                 expired;

  // zero limit is illegal; it behaves as one
  assign eff_max = (cfg.ras_max == '0) ? RAS_MAX_W'(1) : cfg.ras_max;
  assign expired = open_cnt > {1'b0, eff_max};

  always_ff @(posedge clk) begin
    if (!rst_n || do_pre) begin
      open_q   <= 1'b0;
      act_cnt  <= '0;
      wr_cnt   <= WR_SAT;
      open_cnt <= '0;
    end else if (do_act) begin
      open_q   <= 1'b1;
      act_cnt  <= '0;
      wr_cnt   <= WR_SAT;
      open_cnt <= '0;
    end else if (open_q) begin
      if (act_cnt != ACT_SAT) act_cnt <= act_cnt + 1'b1;
      if (do_wr)                 wr_cnt <= '0;
      else if (wr_cnt != WR_SAT) wr_cnt <= wr_cnt + 1'b1;
      if (tick && !expired) open_cnt <= open_cnt + 1'b1;
    end
  end

  assign is_open     = open_q;
  assign pre_ok      = !open_q || ((act_cnt >= cfg.ras_min) && (wr_cnt >= cfg.wr2pre));
  assign force_close = open_q && expired;
endmodule

// File: rtl/bank_pre_tracker.sv
module bank_pre_tracker
  import bpt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_vld,
  input  logic                 wr_vld,
  input  logic                 pre_vld,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [RAS_MIN_W-1:0] cfg_ras_min,
  input  logic [RAS_MAX_W-1:0] cfg_ras_max,
  input  logic [WR2PRE_W-1:0]  cfg_wr2pre,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] force_close,
  output logic                 wr_err
);
  timing_cfg_t          cfg;
  logic                 tick;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_BANKS-1:0] bank_open;
  logic                 wr_miss;

  assign cfg.ras_min = cfg_ras_min;
  assign cfg.wr2pre  = cfg_wr2pre;
  assign cfg.ras_max = cfg_ras_max;

  bpt_prescaler #(.W(TICK_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = (cmd_bank == BANK_W'(b));

    bpt_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .do_act     (act_vld && bank_sel[b]),
      .do_wr      (wr_vld  && bank_sel[b]),
      .do_pre     (pre_vld && bank_sel[b]),
      .tick       (tick),
      .cfg        (cfg),
      .is_open    (bank_open[b]),
      .pre_ok     (pre_ok[b]),
      .force_close(force_close[b])
    );
  end

  assign wr_miss = wr_vld && !act_vld && !pre_vld && ((bank_open & bank_sel) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_miss;
  end
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 act_vld,
  input logic                 wr_vld,
  input logic                 pre_vld,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [5:0]           cfg_ras_min,
  input logic [6:0]           cfg_wr2pre,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] pre_ok,
  input logic [NUM_BANKS-1:0] force_close,
  input logic                 wr_err
);
  p_single_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_vld, wr_vld, pre_vld}));

  p_act_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && cfg_ras_min != 6'd0) |=> !pre_ok[$past(cmd_bank)]);

  p_wr_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && bank_open[cmd_bank] && cfg_wr2pre != 7'd0) |=> !pre_ok[$past(cmd_bank)]);

  p_pre_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_vld |=> (pre_ok[$past(cmd_bank)] && !force_close[$past(cmd_bank)]));

  p_miss_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && !bank_open[cmd_bank]) |=> wr_err);

  p_closed_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((~bank_open & ~pre_ok) == '0) && ((~bank_open & force_close) == '0));
endmodule

bind bank_pre_tracker bpt_checker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_bpt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_vld    (act_vld),
  .wr_vld     (wr_vld),
  .pre_vld    (pre_vld),
  .cmd_bank   (cmd_bank),
  .cfg_ras_min(cfg_ras_min),
  .cfg_wr2pre (cfg_wr2pre),
  .bank_open  (bank_open),
  .pre_ok     (pre_ok),
  .force_close(force_close),
  .wr_err     (wr_err)
);

// File: tb/bank_pre_tracker_bench.sv
module bank_pre_tracker_bench;
  localparam int NB = 8;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_vld = 1'b0, wr_vld = 1'b0, pre_vld = 1'b0;
  logic [BW-1:0] cmd_bank = '0;
  logic [5:0]    cfg_ras_min = 6'd0;
  logic [6:0]    cfg_ras_max = 7'd1;
  logic [6:0]    cfg_wr2pre = 7'd0;
  logic [NB-1:0] pre_ok, force_close;
  logic          wr_err;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  bank_pre_tracker #(.NUM_BANKS(NB)) u_bank_pre_tracker (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .wr_vld(wr_vld), .pre_vld(pre_vld),
    .cmd_bank(cmd_bank), .cfg_ras_min(cfg_ras_min), .cfg_ras_max(cfg_ras_max),
    .cfg_wr2pre(cfg_wr2pre), .pre_ok(pre_ok), .force_close(force_close), .wr_err(wr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // kind: 0 activate, 1 write, 2 precharge
  task automatic issue(input int kind, input int bank);
    cmd_bank = BW'(bank);
    act_vld  = (kind == 0);
    wr_vld   = (kind == 1);
    pre_vld  = (kind == 2);
    @(posedge clk);
    @(negedge clk);
    act_vld = 1'b0; wr_vld = 1'b0; pre_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 pre_ok", int'(pre_ok), 255);
    chk("R1 force_close", int'(force_close), 0);
    chk("R1 wr_err", int'(wr_err), 0);

    // R2 sweep of minimum active time
    cfg_wr2pre = 7'd0;
    for (int rm = 0; rm < 6; rm++) begin
      cfg_ras_min = 6'(rm);
      issue(0, 3);
      for (int k = 0; k < 8; k++) begin
        chk($sformatf("R2 rm=%0d k=%0d", rm, k), int'(pre_ok[3]), int'(k >= rm));
        step(1);
      end
      issue(2, 3);
    end

    // R3 sweep of write-to-precharge time
    cfg_ras_min = 6'd0;
    for (int wp = 0; wp < 6; wp++) begin
      cfg_wr2pre = 7'(wp);
      issue(0, 5);
      issue(1, 5);
      chk("R3 no error on open write", int'(wr_err), 0);
      for (int k = 0; k < 8; k++) begin
        chk($sformatf("R3 wp=%0d k=%0d", wp, k), int'(pre_ok[5]), int'(k >= wp));
        step(1);
      end
      issue(2, 5);
    end

    // R4 both delays combined: activate, write at act k=2
    cfg_ras_min = 6'd5;
    cfg_wr2pre  = 7'd4;
    issue(0, 1);
    chk("R9 other bank untouched", int'(pre_ok[2]), 1);
    chk("R4 blocked after activate", int'(pre_ok[1]), 0);
    step(1);
    issue(1, 1);
    for (int j = 0; j < 7; j++) begin
      chk($sformatf("R4 combined j=%0d", j), int'(pre_ok[1]), int'(j >= 4));
      step(1);
    end
    issue(2, 1);

    // R4 later write restarts the delay
    cfg_ras_min = 6'd0;
    issue(0, 1);
    issue(1, 1);
    step(2);
    issue(1, 1);
    for (int j = 0; j < 6; j++) begin
      chk($sformatf("R4 restart j=%0d", j), int'(pre_ok[1]), int'(j >= 4));
      step(1);
    end
    issue(2, 1);

    // R8 write to a closed bank
    issue(1, 6);
    chk("R8 wr_err pulse", int'(wr_err), 1);
    chk("R8 bank stays closed", int'(pre_ok[6]), 1);
    step(1);
    chk("R8 wr_err one cycle", int'(wr_err), 0);

    // R7 precharge clears unmet timers
    cfg_ras_min = 6'd20;
    issue(0, 4);
    chk("R7 blocked before precharge", int'(pre_ok[4]), 0);
    issue(2, 4);
    chk("R7 pre_ok after precharge", int'(pre_ok[4]), 1);

    // R5 page-open limit of 2 units
    cfg_ras_min = 6'd0;
    cfg_ras_max = 7'd2;
    issue(0, 0);
    step(2048);
    chk("R5 not yet at limit*1024", int'(force_close[0]), 0);
    chk("R9 other banks no force", int'(force_close[7:1]), 0);
    step(1024);
    chk("R5 raised by (limit+1)*1024", int'(force_close[0]), 1);
    chk("R9 other banks no force", int'(force_close[7:1]), 0);
    issue(2, 0);
    chk("R7 force cleared", int'(force_close[0]), 0);
    chk("R7 pre_ok after close", int'(pre_ok[0]), 1);

    // R6 zero limit behaves as one
    cfg_ras_max = 7'd0;
    issue(0, 7);
    step(1024);
    chk("R6 not yet at 1024", int'(force_close[7]), 0);
    step(1024);
    chk("R6 raised by 2048", int'(force_close[7]), 1);
    issue(2, 7);
    chk("R7 force cleared bank7", int'(force_close[7]), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule